// File: doc/BRIEF.md
# Clock Output Enable Gating Logic

This block decides, cycle by cycle, which of 19 differential clock outputs may drive and which must float. Each output is driven only when three conditions agree: its enable pin permits it, its software enable bit permits it, and the device is both powered up and past its power-up sequence. Pins are shared unevenly. Outputs 0 to 4 follow one common active-low pin. Outputs 17 and 18 follow a second common pin. Outputs 5 to 16 each follow a pin of their own.

The pin inputs and the power-down input arrive from the board without a clock relation, so they pass through a synchronizer before they are used. The synchronized pin levels are also presented on a readback vector, so that a register interface elsewhere can report them to software. The result is registered, which lets every change take effect on a clock edge. The result is given twice: as an enable vector and as its tri-state complement for the pad drivers.

Top module: `clk_oe_gate`

## Requirements
- R1: After reset, `out_en[i]` is 1 only when the pin governing output i is low, `reg_en[i]` is 1, `pd_n` is high and `seq_ready` is high. Any other combination gives 0.
- R2: `grp_lo_en_n` governs outputs 0 to 4 together. Its level has no effect on any other output.
- R3: `grp_hi_en_n` governs outputs 17 and 18 together. Its level has no effect on any other output.
- R4: `solo_en_n[k]` governs output k+5 alone, for k from 0 to 11.
- R5: While `pd_n` is low, every output is disabled, whatever the pins and enable bits say.
- R6: While `seq_ready` is low, every output is disabled.
- R7: `out_hiz[i]` is always the complement of `out_en[i]`. A value of 1 means both legs of pair i float.
- R8: A change on a pin or on `pd_n` reaches `out_en` on the third rising edge after it. A change on `reg_en` or `seq_ready` reaches `out_en` on the next rising edge.
- R9: `pin_rb` carries the raw pin levels two edges after they are applied. Bit 0 is `grp_lo_en_n`, bits 12:1 are `solo_en_n[11:0]`, and bit 13 is `grp_hi_en_n`.
- R10: While `rst_n` is low at a rising edge, `out_en` becomes all zeros, `out_hiz` becomes all ones, and `pin_rb` becomes all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| grp_lo_en_n | input | 1 | Common enable pin for outputs 0 to 4, active low, asynchronous |
| solo_en_n | input | 12 | Individual enable pins for outputs 5 to 16, active low, asynchronous |
| grp_hi_en_n | input | 1 | Common enable pin for outputs 17 and 18, active low, asynchronous |
| reg_en | input | 19 | Software enable bit per output, 1 = allowed |
| pd_n | input | 1 | Power-down input, low = all outputs off, asynchronous |
| seq_ready | input | 1 | Power-up sequencer has reached normal operation |
| out_en | output | 19 | Registered drive enable per output |
| out_hiz | output | 19 | Registered tri-state indication per output |
| pin_rb | output | 14 | Synchronized pin levels for register readback |

## Verification
The bench builds the block with its default parameters: 19 outputs, the low group ending at output 4, the high group starting at output 17, and a two-stage synchronizer. With these values the bench can reach both group boundaries (outputs 4/5 and 16/17) and walk every one of the twelve individual pins. It can also measure the three-edge pin latency against the one-edge register latency. A behavioural model, built from history queues, is compared with all three outputs on every clock. This covers power-down and sequencer overrides as they arrive in the middle of a run, and a reset applied during operation.

// File: rtl/clk_oe_pkg.sv
`timescale 1ns/1ps
// Package: clk_oe_pkg
// Shared helpers for the clock output enable gating logic.
// Assumes the packed pin vector holds the low group pin in slot 0, the
// individual pins in ascending output order, then the high group pin.
package clk_oe_pkg;

    // Return the slot of the packed pin vector that governs one output.
    function automatic int unsigned pin_slot(input int unsigned out_idx,
                                             input int unsigned lo_last,
                                             input int unsigned hi_first);
        if (out_idx <= lo_last)
            return 0;
        else if (out_idx >= hi_first)
            return hi_first - lo_last;
        else
            return out_idx - lo_last;
    endfunction

endpackage

// File: rtl/clk_oe_sync.sv
`timescale 1ns/1ps
// Module: clk_oe_sync
// Multi-stage synchronizer for a vector of asynchronous levels.
// Assumes each bit is an independent quasi-static level, so the bits need
// no coherence with one another. The reset value is chosen by the parent.
module clk_oe_sync #(
    parameter int unsigned   W       = 1,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int unsigned CW = $clog2(STAGES + 1) + 1;

    logic [W-1:0]  chain [STAGES];
    logic [CW-1:0] since_rst;

    // Shift the input levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    // Count active edges since reset, saturating once the chain is filled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != CW'(STAGES))
            since_rst <= since_rst + 1'b1;
    end

    assign q = chain[STAGES-1];

    // R8: once the chain is filled, the output equals the input STAGES edges back.
    assert_sync_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == CW'(STAGES)) |-> (q == $past(d, STAGES)));

endmodule

// File: rtl/clk_oe_fanout.sv
`timescale 1ns/1ps
// Module: clk_oe_fanout
// Spreads the packed, active-low pin levels onto one active-high permit per
// output. Outputs up to LO_LAST share slot 0, outputs from HI_FIRST upward
// share the last slot, and every output in between has a slot of its own.
// Assumes LO_LAST < HI_FIRST < OUT_N.
module clk_oe_fanout
    import clk_oe_pkg::*;
#(
    parameter int unsigned OUT_N    = 19,
    parameter int unsigned LO_LAST  = 4,
    parameter int unsigned HI_FIRST = 17,
    localparam int unsigned PIN_W   = HI_FIRST - LO_LAST + 1
) (
    input  logic [PIN_W-1:0] pin_lvl,
    output logic [OUT_N-1:0] pin_ok
);
    // One permit per output, taken from the slot that governs it.
    for (genvar i = 0; i < OUT_N; i++) begin : g_out
        localparam int unsigned SLOT = pin_slot(i, LO_LAST, HI_FIRST);
        assign pin_ok[i] = ~pin_lvl[SLOT];
    end

endmodule

// File: rtl/clk_oe_combine.sv
`timescale 1ns/1ps
// Module: clk_oe_combine
// Joins pin permits, software enable bits, the synchronized power state and
// the sequencer flag into a registered drive enable per output. It also
// registers the tri-state complement for the pad drivers.
// Assumes pin_ok and pd_ok are already synchronous to clk.
module clk_oe_combine #(
    parameter int unsigned OUT_N = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OUT_N-1:0] pin_ok,
    input  logic [OUT_N-1:0] reg_en,
    input  logic             pd_ok,
    input  logic             ready,
    output logic [OUT_N-1:0] out_en,
    output logic [OUT_N-1:0] out_hiz
);
    logic             global_ok;
    logic [OUT_N-1:0] en_nxt;

    // Form the enable each output should have after the next edge.
    always_comb begin
        global_ok = pd_ok & ready;
        en_nxt    = pin_ok & reg_en & {OUT_N{global_ok}};
    end

    // Register the enables and their float indication together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en  <= '0;
            out_hiz <= '1;
        end else begin
            out_en  <= en_nxt;
            out_hiz <= ~en_nxt;
        end
    end

    // R5: power down seen by the logic empties the enable vector on the next edge.
    assert_pd_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_ok |=> (out_en == '0));

    // R6: sequencer not ready empties the enable vector on the next edge.
    assert_seq_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (out_en == '0));

    for (genvar i = 0; i < OUT_N; i++) begin : g_chk
        // R1: a driven output had both its pin permit and its register bit.
        assert_both_permit_R1: assert property (@(posedge clk) disable iff (!rst_n)
            out_en[i] |-> $past(pin_ok[i] && reg_en[i]));
        // R7: a driven output never reports float.
        assert_hiz_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_en[i]) |-> $fell(out_hiz[i]));
    end

endmodule

// File: rtl/clk_oe_gate.sv
`timescale 1ns/1ps
// Module: clk_oe_gate
// Top of the clock output enable gating logic. Synchronizes the enable pins
// and the power-down input, presents the synchronized pin levels for readback,
// spreads the pins onto outputs and registers the combined enables.
// Assumes reg_en and seq_ready are already synchronous to clk.
module clk_oe_gate #(
    parameter int unsigned OUT_N       = 19,
    parameter int unsigned LO_LAST     = 4,
    parameter int unsigned HI_FIRST    = 17,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned SOLO_W     = HI_FIRST - LO_LAST - 1,
    localparam int unsigned PIN_W      = SOLO_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grp_lo_en_n,
    input  logic [SOLO_W-1:0] solo_en_n,
    input  logic              grp_hi_en_n,
    input  logic [OUT_N-1:0]  reg_en,
    input  logic              pd_n,
    input  logic              seq_ready,
    output logic [OUT_N-1:0]  out_en,
    output logic [OUT_N-1:0]  out_hiz,
    output logic [PIN_W-1:0]  pin_rb
);
    logic [PIN_W-1:0] pin_raw;
    logic [PIN_W-1:0] pin_sync;
    logic [0:0]       pd_sync;
    logic [OUT_N-1:0] pin_ok;

    assign pin_raw = {grp_hi_en_n, solo_en_n, grp_lo_en_n};

    // Pins reset to the disabling level so nothing drives before real data.
    clk_oe_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({PIN_W{1'b1}})
    ) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (pin_sync)
    );

    // Power state resets to powered down.
    clk_oe_sync #(
        .W       (1),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_pd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pd_n),
        .q     (pd_sync)
    );

    clk_oe_fanout #(
        .OUT_N    (OUT_N),
        .LO_LAST  (LO_LAST),
        .HI_FIRST (HI_FIRST)
    ) u_fanout (
        .pin_lvl (pin_sync),
        .pin_ok  (pin_ok)
    );

    clk_oe_combine #(
        .OUT_N (OUT_N)
    ) u_combine (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_ok  (pin_ok),
        .reg_en  (reg_en),
        .pd_ok   (pd_sync[0]),
        .ready   (seq_ready),
        .out_en  (out_en),
        .out_hiz (out_hiz)
    );

    assign pin_rb = pin_sync;

    // R2: outputs in the low group always agree when their register bits agree.
    assert_lo_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_en[0]) && $past(reg_en[LO_LAST])) |-> (out_en[0] == out_en[LO_LAST]));

    // R3: outputs in the high group always agree when their register bits agree.
    assert_hi_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_en[HI_FIRST]) && $past(reg_en[OUT_N-1])) |-> (out_en[HI_FIRST] == out_en[OUT_N-1]));

endmodule

// File: tb/clk_oe_gate_test.sv
`timescale 1ns/1ps
// Bench for clk_oe_gate: behavioural history-queue model compared every clock,
// plus directed checks tagged by requirement.
module clk_oe_gate_test;
    localparam int N  = 19;
    localparam int SW = 12;
    localparam int PW = 14;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          glo, ghi, pd_n, rdy;
    logic [SW-1:0] solo;
    logic [N-1:0]  regb;
    logic [N-1:0]  en, hiz;
    logic [PW-1:0] rb;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    bit    model_ok = 0;
    string phase = "R10";

    always #2.5 clk = ~clk;

    clk_oe_gate uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .grp_lo_en_n (glo),
        .solo_en_n   (solo),
        .grp_hi_en_n (ghi),
        .reg_en      (regb),
        .pd_n        (pd_n),
        .seq_ready   (rdy),
        .out_en      (en),
        .out_hiz     (hiz),
        .pin_rb      (rb)
    );

    typedef struct packed {
        logic          ghi;
        logic [SW-1:0] solo;
        logic          glo;
        logic          pd;
    } snap_t;

    snap_t        hist[$];
    logic [N-1:0] exp_en;
    logic [PW-1:0] exp_rb;

    function automatic logic [N-1:0] ref_en(snap_t s, logic [N-1:0] r, logic rd);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) begin
            logic low;
            if (i <= 4)       low = !s.glo;
            else if (i >= 17) low = !s.ghi;
            else              low = !s.solo[i-5];
            v[i] = s.pd & rd & r[i] & low;
        end
        return v;
    endfunction

    // Reference model: pins and power state act two edges late, register bits at once.
    always @(posedge clk) begin
        snap_t cur, old;
        if (!rst_n) begin
            hist.delete();
            hist.push_back('{ghi: 1'b1, solo: '1, glo: 1'b1, pd: 1'b0});
            hist.push_back('{ghi: 1'b1, solo: '1, glo: 1'b1, pd: 1'b0});
            exp_en = '0;
            exp_rb = '1;
        end else begin
            cur = '{ghi: ghi, solo: solo, glo: glo, pd: pd_n};
            hist.push_back(cur);
            old = hist.pop_front();
            exp_en = ref_en(old, regb, rdy);
            exp_rb = {hist[0].ghi, hist[0].solo, hist[0].glo};
        end
        model_ok = 1;
    end

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare all outputs with the model every cycle.
    always @(negedge clk) begin
        if (model_ok && !done) begin
            logic [N-1:0] exp_hiz;
            exp_hiz = ~exp_en;
            chk({phase, " en"}, 64'(en), 64'(exp_en));
            chk({phase, " R7 hiz"}, 64'(hiz), 64'(exp_hiz));
            chk({phase, " R9 rb"}, 64'(rb), 64'(exp_rb));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; glo = 1; ghi = 1; solo = '1; pd_n = 0; rdy = 0; regb = '1;
        step(3);
        @(negedge clk);
        chk("R10 reset en", 64'(en), 64'(0));
        chk("R10 reset hiz", 64'(hiz), 64'(19'h7FFFF));
        chk("R10 reset rb", 64'(rb), 64'(14'h3FFF));

        step(0);
        @(posedge clk); #1;
        phase = "R5"; rst_n = 1; glo = 0; ghi = 0; solo = '0; rdy = 1;
        step(5);
        @(negedge clk);
        chk("R5 powered down", 64'(en), 64'(0));

        phase = "R1"; pd_n = 1;
        step(4);
        @(negedge clk);
        chk("R1 all enabled", 64'(en), 64'(19'h7FFFF));

        // R8: pin change needs three edges to reach the output.
        @(posedge clk); #1;
        phase = "R8"; glo = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 pin after 1 edge", 64'(en[4:0]), 64'(5'h1F));
        chk("R9 rb after 1 edge", 64'(rb[0]), 64'(0));
        @(negedge clk);
        chk("R8 pin after 2 edges", 64'(en[4:0]), 64'(5'h1F));
        chk("R9 rb after 2 edges", 64'(rb[0]), 64'(1));
        @(negedge clk);
        chk("R8 pin after 3 edges", 64'(en[4:0]), 64'(0));
        phase = "R2";
        chk("R2 low group off, 5 on", 64'(en[5]), 64'(1));
        chk("R2 others untouched", 64'(en[18:5]), 64'(14'h3FFF));

        // R8: register bit reaches the output on the next edge.
        @(posedge clk); #1;
        phase = "R8"; regb[10] = 0;
        @(negedge clk);
        chk("R8 reg before edge", 64'(en[10]), 64'(1));
        @(negedge clk);
        chk("R8 reg after edge", 64'(en[10]), 64'(0));
        @(posedge clk); #1;
        regb[10] = 1; glo = 0;
        phase = "R3"; ghi = 1;
        step(4);
        @(negedge clk);
        chk("R3 high group off", 64'(en[18:17]), 64'(0));
        chk("R3 others on", 64'(en[16:0]), 64'(17'h1FFFF));
        ghi = 0;
        step(4);

        phase = "R4";
        for (int k = 0; k < SW; k++) begin
            solo = SW'(1) << k;
            step(4);
            @(negedge clk);
            chk("R4 single pin", 64'(en), 64'(~(19'(1) << (k + 5)) & 19'h7FFFF));
            chk("R9 rb single pin", 64'(rb), 64'({1'b0, solo, 1'b0}));
        end
        solo = '0;
        step(4);

        phase = "R1";
        for (int i = 0; i < N; i++) begin
            regb = ~(19'(1) << i);
            step(2);
            @(negedge clk);
            chk("R1 reg bit walk", 64'(en), 64'(regb));
        end
        regb = '1;
        solo[0] = 1; regb[5] = 0;
        step(4);
        @(negedge clk);
        chk("R1 pin and bit both off", 64'(en[5]), 64'(0));
        solo[0] = 0; regb[5] = 1;
        step(4);

        phase = "R6"; rdy = 0;
        step(2);
        @(negedge clk);
        chk("R6 not ready", 64'(en), 64'(0));
        rdy = 1;
        step(2);
        @(negedge clk);
        chk("R6 ready again", 64'(en), 64'(19'h7FFFF));

        phase = "R5"; pd_n = 0;
        step(4);
        @(negedge clk);
        chk("R5 override", 64'(en), 64'(0));
        chk("R7 all float", 64'(hiz), 64'(19'h7FFFF));
        pd_n = 1;
        step(4);

        phase = "R7"; regb = 19'h55555;
        step(2);
        @(negedge clk);
        chk("R7 hiz complement", 64'(hiz), 64'(19'h2AAAA));
        regb = '1;

        phase = "R9"; solo = 12'hA5C; glo = 1; ghi = 0;
        step(3);
        @(negedge clk);
        chk("R9 pattern", 64'(rb), 64'({1'b0, 12'hA5C, 1'b1}));

        phase = "R10"; rst_n = 0;
        step(2);
        @(negedge clk);
        chk("R10 mid-run reset en", 64'(en), 64'(0));
        chk("R10 mid-run reset rb", 64'(rb), 64'(14'h3FFF));

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule